// File: doc/BRIEF.md
# Four-Station Sector Coincidence Finder

This block searches one bunch crossing at a time for muon track candidates at the sector level. Each crossing brings a hit bit for every sector of four detector stations, M2, M3, M4 and M5, and a bunch crossing number. A candidate is anchored on a hit sector of M3. The other three stations must each show a hit in a sector whose index lies close to that M3 sector. For every candidate it reports the four sector addresses, tagged with the crossing number, so that a later detailed stage knows which regions to examine.

A new crossing is accepted on every clock with no stall. The block is fully pipelined with a fixed latency. The number of candidates reported per crossing is limited by a parameter. Candidates are chosen by lowest M3 index, and a flag shows when some had to be dropped. The sector count, the alignment tolerance, the slot count and the crossing-number width are parameters.

Top module: `sc_coinc_finder`

## Requirements
- R1: An M3 sector s is a candidate exactly when hit_m3[s] is set and each of M2, M4 and M5 has at least one hit at an index i with |i - s| <= TOL (default TOL = 1).
- R2: For a reported candidate, the M3 address is s. Each of the M2, M4 and M5 addresses is the lowest hit index inside that station's window around s. Addresses are AW = clog2(NSECT) bits wide, 6 bits by default.
- R3: Windows are clipped at sector 0 and sector NSECT-1 and do not wrap, so a hit at 47 never aligns with M3 sector 0.
- R4: At most MAXC candidates (default 2) are reported per crossing. They are the lowest-index M3 candidates, and slot k holds the k-th lowest. Slot k occupies bits [k*AW +: AW] of each address port and bit k of cand_valid.
- R5: cand_ovf is 1 exactly when the crossing has more than MAXC candidates. Exactly MAXC candidates leave it at 0.
- R6: An unused slot has its valid bit at 0 and all four of its addresses at 0.
- R7: Sector bits and in_bcid present at rising edge t appear on the outputs after rising edge t+2, three register stages in all. A new crossing is taken every cycle, and out_bcid carries the number of the crossing that produced the result.
- R8: While rst is high, all valid bits, cand_ovf and out_bcid are 0 after the next edge.
- R9: If any one of the four stations has no hit in the window, no candidate is reported for that M3 sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per crossing |
| rst | input | 1 | Synchronous active-high reset |
| hit_m2 | input | NSECT | M2 sector hits |
| hit_m3 | input | NSECT | M3 sector hits |
| hit_m4 | input | NSECT | M4 sector hits |
| hit_m5 | input | NSECT | M5 sector hits |
| in_bcid | input | BCW | Crossing number of the input |
| cand_valid | output | MAXC | Valid bit for each slot |
| cand_m2 | output | MAXC*AW | M2 address for each slot |
| cand_m3 | output | MAXC*AW | M3 address for each slot |
| cand_m4 | output | MAXC*AW | M4 address for each slot |
| cand_m5 | output | MAXC*AW | M5 address for each slot |
| cand_ovf | output | 1 | More candidates than slots |
| out_bcid | output | BCW | Crossing number of the result |

## Verification
The bench builds the block with its defaults: 48 sectors, a tolerance of 1, two slots and a 12-bit crossing number. Two slots let three candidates force the overflow and slot-order cases, while exactly two candidates check that the flag stays low. Tolerance 1 takes the windowed variant, where the lowest-in-window pick and the edge clipping at sectors 0 and 47 can be reached. Back-to-back crossings with distinct numbers check that results stay apart in the pipeline.

// File: rtl/sc_pkg.sv
package sc_pkg;
   // lower edge of a sector window, clipped at zero
   function automatic int win_lo(input int s, input int tol);
      return (s - tol < 0) ? 0 : s - tol;
   endfunction

   // upper edge of a sector window, clipped at the last sector
   function automatic int win_hi(input int s, input int tol, input int n);
      return (s + tol > n - 1) ? n - 1 : s + tol;
   endfunction
endpackage

// File: rtl/sc_pick_lowest.sv
module sc_pick_lowest #(
   parameter int NSECT = 48,
   parameter int AW    = 6,
   parameter int LO    = 0,
   parameter int HI    = 0
) (
   input  logic [NSECT-1:0] hits,
   output logic             found,
   output logic [AW-1:0]    addr
);
   generate
      if (LO < 0 || HI >= NSECT || LO > HI) begin : g_bad
         $error("sc_pick_lowest: window bounds out of range");
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      addr  = '0;
      // walk downwards so the lowest hit is the last one written
      for (int j = HI; j >= LO; j--) begin
         if (hits[j]) begin
            found = 1'b1;
            addr  = AW'(j);
         end
      end
   end
endmodule

// File: rtl/sc_window_match.sv
module sc_window_match #(
   parameter int NSECT = 48,
   parameter int AW    = 6,
   parameter int TOL   = 1
) (
   input  logic [NSECT-1:0]    hit_m2,
   input  logic [NSECT-1:0]    hit_m3,
   input  logic [NSECT-1:0]    hit_m4,
   input  logic [NSECT-1:0]    hit_m5,
   output logic [NSECT-1:0]    match,
   output logic [NSECT*AW-1:0] addr_m2,
   output logic [NSECT*AW-1:0] addr_m4,
   output logic [NSECT*AW-1:0] addr_m5
);
   import sc_pkg::*;

   generate
      for (genvar s = 0; s < NSECT; s++) begin : g_sect
         logic f2, f4, f5;
         if (TOL == 0) begin : g_exact
            // zero tolerance: the only window sector is s itself
            assign f2 = hit_m2[s];
            assign f4 = hit_m4[s];
            assign f5 = hit_m5[s];
            assign addr_m2[s*AW +: AW] = AW'(s);
            assign addr_m4[s*AW +: AW] = AW'(s);
            assign addr_m5[s*AW +: AW] = AW'(s);
         end else begin : g_win
            localparam int LO = win_lo(s, TOL);
            localparam int HI = win_hi(s, TOL, NSECT);
            sc_pick_lowest #(.NSECT(NSECT), .AW(AW), .LO(LO), .HI(HI)) u_p2 (
               .hits(hit_m2), .found(f2), .addr(addr_m2[s*AW +: AW]));
            sc_pick_lowest #(.NSECT(NSECT), .AW(AW), .LO(LO), .HI(HI)) u_p4 (
               .hits(hit_m4), .found(f4), .addr(addr_m4[s*AW +: AW]));
            sc_pick_lowest #(.NSECT(NSECT), .AW(AW), .LO(LO), .HI(HI)) u_p5 (
               .hits(hit_m5), .found(f5), .addr(addr_m5[s*AW +: AW]));
         end
         assign match[s] = hit_m3[s] & f2 & f4 & f5;
      end
   endgenerate
endmodule

// File: rtl/sc_slot_select.sv
module sc_slot_select #(
   parameter int NSECT = 48,
   parameter int AW    = 6,
   parameter int MAXC  = 2
) (
   input  logic [NSECT-1:0]    match,
   input  logic [NSECT*AW-1:0] addr_m2,
   input  logic [NSECT*AW-1:0] addr_m4,
   input  logic [NSECT*AW-1:0] addr_m5,
   output logic [MAXC-1:0]     sel_valid,
   output logic [MAXC*AW-1:0]  sel_m2,
   output logic [MAXC*AW-1:0]  sel_m3,
   output logic [MAXC*AW-1:0]  sel_m4,
   output logic [MAXC*AW-1:0]  sel_m5,
   output logic                sel_ovf
);
   logic [NSECT-1:0] rest;
   int               total;

   always_comb begin
      rest      = match;
      sel_valid = '0;
      sel_m2    = '0;
      sel_m3    = '0;
      sel_m4    = '0;
      sel_m5    = '0;
      for (int k = 0; k < MAXC; k++) begin
         for (int j = 0; j < NSECT; j++) begin
            if (!sel_valid[k] && rest[j]) begin
               sel_valid[k]        = 1'b1;
               sel_m3[k*AW +: AW]  = AW'(j);
               sel_m2[k*AW +: AW]  = addr_m2[j*AW +: AW];
               sel_m4[k*AW +: AW]  = addr_m4[j*AW +: AW];
               sel_m5[k*AW +: AW]  = addr_m5[j*AW +: AW];
               rest[j]             = 1'b0;
            end
         end
      end
   end

   always_comb begin
      total = 0;
      for (int j = 0; j < NSECT; j++) total = total + int'(match[j]);
   end

   assign sel_ovf = (total > MAXC);
endmodule

// File: rtl/sc_coinc_finder.sv
module sc_coinc_finder #(
   parameter int NSECT = 48,
   parameter int TOL   = 1,
   parameter int MAXC  = 2,
   parameter int BCW   = 12,
   localparam int AW   = $clog2(NSECT)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NSECT-1:0]    hit_m2,
   input  logic [NSECT-1:0]    hit_m3,
   input  logic [NSECT-1:0]    hit_m4,
   input  logic [NSECT-1:0]    hit_m5,
   input  logic [BCW-1:0]      in_bcid,
   output logic [MAXC-1:0]     cand_valid,
   output logic [MAXC*AW-1:0]  cand_m2,
   output logic [MAXC*AW-1:0]  cand_m3,
   output logic [MAXC*AW-1:0]  cand_m4,
   output logic [MAXC*AW-1:0]  cand_m5,
   output logic                cand_ovf,
   output logic [BCW-1:0]      out_bcid
);
   generate
      if (NSECT < 2)              begin : g_e0 $error("NSECT must be at least 2"); end
      if (TOL < 0 || TOL >= NSECT) begin : g_e1 $error("TOL out of range"); end
      if (MAXC < 1 || MAXC > NSECT) begin : g_e2 $error("MAXC out of range"); end
      if (BCW < 1)                begin : g_e3 $error("BCW must be positive"); end
   endgenerate

   // stage 1: input capture
   logic [NSECT-1:0] s1_m2, s1_m3, s1_m4, s1_m5;
   logic [BCW-1:0]   s1_bc;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_m2 <= '0; s1_m3 <= '0; s1_m4 <= '0; s1_m5 <= '0;
         s1_bc <= '0;
      end else begin
         s1_m2 <= hit_m2; s1_m3 <= hit_m3; s1_m4 <= hit_m4; s1_m5 <= hit_m5;
         s1_bc <= in_bcid;
      end
   end

   // stage 2: per-sector coincidence
   logic [NSECT-1:0]    w_match;
   logic [NSECT*AW-1:0] w_a2, w_a4, w_a5;

   sc_window_match #(.NSECT(NSECT), .AW(AW), .TOL(TOL)) u_win (
      .hit_m2(s1_m2), .hit_m3(s1_m3), .hit_m4(s1_m4), .hit_m5(s1_m5),
      .match(w_match), .addr_m2(w_a2), .addr_m4(w_a4), .addr_m5(w_a5));

   logic [NSECT-1:0]    s2_match;
   logic [NSECT*AW-1:0] s2_a2, s2_a4, s2_a5;
   logic [BCW-1:0]      s2_bc;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_match <= '0;
         s2_a2 <= '0; s2_a4 <= '0; s2_a5 <= '0;
         s2_bc <= '0;
      end else begin
         s2_match <= w_match;
         s2_a2 <= w_a2; s2_a4 <= w_a4; s2_a5 <= w_a5;
         s2_bc <= s1_bc;
      end
   end

   // stage 3: slot selection and output register
   logic [MAXC-1:0]    q_valid;
   logic [MAXC*AW-1:0] q_m2, q_m3, q_m4, q_m5;
   logic               q_ovf;

   sc_slot_select #(.NSECT(NSECT), .AW(AW), .MAXC(MAXC)) u_sel (
      .match(s2_match), .addr_m2(s2_a2), .addr_m4(s2_a4), .addr_m5(s2_a5),
      .sel_valid(q_valid), .sel_m2(q_m2), .sel_m3(q_m3), .sel_m4(q_m4),
      .sel_m5(q_m5), .sel_ovf(q_ovf));

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_valid <= '0;
         cand_m2 <= '0; cand_m3 <= '0; cand_m4 <= '0; cand_m5 <= '0;
         cand_ovf <= 1'b0;
         out_bcid <= '0;
      end else begin
         cand_valid <= q_valid;
         cand_m2 <= q_m2; cand_m3 <= q_m3; cand_m4 <= q_m4; cand_m5 <= q_m5;
         cand_ovf <= q_ovf;
         out_bcid <= s2_bc;
      end
   end
endmodule

// File: rtl/sc_coinc_chk.sv
module sc_coinc_chk #(
   parameter int NSECT = 48,
   parameter int TOL   = 1,
   parameter int MAXC  = 2,
   parameter int BCW   = 12,
   localparam int AW   = $clog2(NSECT)
) (
   input logic               clk,
   input logic               rst,
   input logic [BCW-1:0]     in_bcid,
   input logic [MAXC-1:0]    cand_valid,
   input logic [MAXC*AW-1:0] cand_m2,
   input logic [MAXC*AW-1:0] cand_m3,
   input logic [MAXC*AW-1:0] cand_m4,
   input logic [MAXC*AW-1:0] cand_m5,
   input logic               cand_ovf,
   input logic [BCW-1:0]     out_bcid
);
   // cycles since reset, saturating at the pipeline depth
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   int d2, d4, d5;
   always_comb begin
      d2 = int'(cand_m2[AW-1:0]) - int'(cand_m3[AW-1:0]);
      d4 = int'(cand_m4[AW-1:0]) - int'(cand_m3[AW-1:0]);
      d5 = int'(cand_m5[AW-1:0]) - int'(cand_m3[AW-1:0]);
   end

   // R8
   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (cand_valid == '0 && !cand_ovf && out_bcid == '0));

   // R7
   a_r7_bcid_follows: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_bcid == $past(in_bcid, 3)));

   // R2
   a_r2_slot0_in_window: assert property (@(posedge clk) disable iff (rst)
      cand_valid[0] |-> (d2 <= TOL && d2 >= -TOL && d4 <= TOL && d4 >= -TOL
                         && d5 <= TOL && d5 >= -TOL));

   // R5
   a_r5_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
      cand_ovf |-> (cand_valid == {MAXC{1'b1}}));

   // R4
   a_r4_slots_packed: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cand_valid + 1'b1) || cand_valid == '0);

   generate
      if (MAXC > 1) begin : g_order
         // R4
         a_r4_slot_order: assert property (@(posedge clk) disable iff (rst)
            cand_valid[1] |-> (cand_m3[AW +: AW] > cand_m3[AW-1:0]));
      end
   endgenerate

   // R6
   a_r6_empty_slot0_zero: assert property (@(posedge clk) disable iff (rst)
      !cand_valid[0] |-> (cand_m2[AW-1:0] == '0 && cand_m3[AW-1:0] == '0
                          && cand_m4[AW-1:0] == '0 && cand_m5[AW-1:0] == '0));
endmodule

bind sc_coinc_finder sc_coinc_chk #(
   .NSECT(NSECT), .TOL(TOL), .MAXC(MAXC), .BCW(BCW)
) u_chk (
   .clk(clk), .rst(rst), .in_bcid(in_bcid), .cand_valid(cand_valid),
   .cand_m2(cand_m2), .cand_m3(cand_m3), .cand_m4(cand_m4), .cand_m5(cand_m5),
   .cand_ovf(cand_ovf), .out_bcid(out_bcid)
);

// File: tb/tb_sc_coinc_finder.sv
module tb_sc_coinc_finder;
   localparam int NSECT = 48;
   localparam int TOL   = 1;
   localparam int MAXC  = 2;
   localparam int BCW   = 12;
   localparam int AW    = 6;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [NSECT-1:0]   hit_m2 = '0, hit_m3 = '0, hit_m4 = '0, hit_m5 = '0;
   logic [BCW-1:0]     in_bcid = '0;
   logic [MAXC-1:0]    cand_valid;
   logic [MAXC*AW-1:0] cand_m2, cand_m3, cand_m4, cand_m5;
   logic               cand_ovf;
   logic [BCW-1:0]     out_bcid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   sc_coinc_finder #(.NSECT(NSECT), .TOL(TOL), .MAXC(MAXC), .BCW(BCW)) dut (
      .clk(clk), .rst(rst), .hit_m2(hit_m2), .hit_m3(hit_m3), .hit_m4(hit_m4),
      .hit_m5(hit_m5), .in_bcid(in_bcid), .cand_valid(cand_valid),
      .cand_m2(cand_m2), .cand_m3(cand_m3), .cand_m4(cand_m4), .cand_m5(cand_m5),
      .cand_ovf(cand_ovf), .out_bcid(out_bcid));

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NSECT-1:0] bit_at(input int i);
      logic [NSECT-1:0] v = '0;
      v[i] = 1'b1;
      return v;
   endfunction

   task automatic drive(input logic [NSECT-1:0] a2, input logic [NSECT-1:0] a3,
                        input logic [NSECT-1:0] a4, input logic [NSECT-1:0] a5,
                        input int bc);
      hit_m2 = a2; hit_m3 = a3; hit_m4 = a4; hit_m5 = a5;
      in_bcid = BCW'(bc);
   endtask

   // checks one slot: valid flag and the four addresses
   task automatic chk_slot(input string req, input int k, input int v,
                           input int e2, input int e3, input int e4, input int e5);
      chk(req, $sformatf("slot%0d valid", k), int'(cand_valid[k]), v);
      chk(req, $sformatf("slot%0d m2", k), int'(cand_m2[k*AW +: AW]), e2);
      chk(req, $sformatf("slot%0d m3", k), int'(cand_m3[k*AW +: AW]), e3);
      chk(req, $sformatf("slot%0d m4", k), int'(cand_m4[k*AW +: AW]), e4);
      chk(req, $sformatf("slot%0d m5", k), int'(cand_m5[k*AW +: AW]), e5);
   endtask

   // one crossing: drive at a falling edge, sample three falling edges later
   task automatic one_crossing(input logic [NSECT-1:0] a2, input logic [NSECT-1:0] a3,
                               input logic [NSECT-1:0] a4, input logic [NSECT-1:0] a5,
                               input int bc);
      @(negedge clk);
      drive(a2, a3, a4, a5, bc);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R8", "valid in reset", int'(cand_valid), 0);
      chk("R8", "ovf in reset", int'(cand_ovf), 0);
      chk("R8", "bcid in reset", int'(out_bcid), 0);
   endtask

   task automatic t_straight;
      one_crossing(bit_at(10), bit_at(10), bit_at(10), bit_at(10), 101);
      chk_slot("R1", 0, 1, 10, 10, 10, 10);
      chk_slot("R6", 1, 0, 0, 0, 0, 0);
      chk("R5", "ovf single", int'(cand_ovf), 0);
      chk("R7", "bcid single", int'(out_bcid), 101);
   endtask

   task automatic t_offset;
      // M2 has hits at 19 and 21: the lower one is reported
      one_crossing(bit_at(19) | bit_at(21), bit_at(20), bit_at(21), bit_at(21), 102);
      chk_slot("R2", 0, 1, 19, 20, 21, 21);
   endtask

   task automatic t_outside;
      one_crossing(bit_at(32), bit_at(30), bit_at(30), bit_at(30), 103);
      chk("R1", "M2 two sectors away", int'(cand_valid), 0);
      chk_slot("R6", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_missing;
      one_crossing(bit_at(8), bit_at(8), bit_at(8), '0, 104);
      chk("R9", "M5 empty", int'(cand_valid), 0);
      one_crossing(bit_at(8), '0, bit_at(8), bit_at(8), 105);
      chk("R9", "M3 empty", int'(cand_valid), 0);
   endtask

   task automatic t_edges;
      one_crossing(bit_at(47), bit_at(0), bit_at(0), bit_at(1), 106);
      chk("R3", "no wrap at sector 0", int'(cand_valid), 0);
      one_crossing(bit_at(47), bit_at(47), bit_at(46), bit_at(47), 107);
      chk_slot("R3", 0, 1, 47, 47, 46, 47);
      one_crossing(bit_at(1), bit_at(0), bit_at(0), bit_at(0), 108);
      chk_slot("R3", 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_overflow;
      logic [NSECT-1:0] v;
      v = bit_at(5) | bit_at(15) | bit_at(25);
      one_crossing(v, v, v, v, 109);
      chk_slot("R4", 0, 1, 5, 5, 5, 5);
      chk_slot("R4", 1, 1, 15, 15, 15, 15);
      chk("R5", "ovf with three", int'(cand_ovf), 1);
      v = bit_at(25) | bit_at(40);
      one_crossing(v, v, v, v, 110);
      chk_slot("R4", 0, 1, 25, 25, 25, 25);
      chk_slot("R4", 1, 1, 40, 40, 40, 40);
      chk("R5", "ovf with exactly two", int'(cand_ovf), 0);
   endtask

   task automatic t_stream;
      @(negedge clk); drive(bit_at(3), bit_at(3), bit_at(3), bit_at(3), 201);
      @(negedge clk); drive('0, '0, '0, '0, 202);
      @(negedge clk); drive(bit_at(44), bit_at(43), bit_at(42), bit_at(44), 203);
      @(negedge clk);
      chk("R7", "stream bcid 0", int'(out_bcid), 201);
      chk_slot("R7", 0, 1, 3, 3, 3, 3);
      drive('0, '0, '0, '0, 0);
      @(negedge clk);
      chk("R7", "stream bcid 1", int'(out_bcid), 202);
      chk("R7", "stream empty", int'(cand_valid), 0);
      @(negedge clk);
      chk("R7", "stream bcid 2", int'(out_bcid), 203);
      chk_slot("R7", 0, 1, 44, 43, 42, 44);
   endtask

   task automatic t_rereset;
      logic [NSECT-1:0] v;
      v = bit_at(1) | bit_at(2) | bit_at(3);
      @(negedge clk);
      drive(v, v, v, v, 55);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R8", "valid after reset", int'(cand_valid), 0);
      chk("R8", "ovf after reset", int'(cand_ovf), 0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_straight();
      t_offset();
      t_outside();
      t_missing();
      t_edges();
      t_overflow();
      t_stream();
      t_rereset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule